// File: doc/BRIEF.md
# Serial Converter Command and Result Port

This block is the device side of a four-wire serial link on a 12-bit multi-channel converter. While the active-low select is held low, a host toggles a serial clock. The block first looks for a start bit on the data input and then takes in a seven-bit command. The command picks the input channel and the single-ended or differential mode, chooses unipolar or bipolar coding, and sets the output bit order and a power-down request. After one null bit, the block returns the conversion result on a serial output. That output has its own enable, which stands for the pin's high-impedance control.

The result arrives as a parallel word from an external converter model. The block latches that word when the command completes, and it pulses `conv_start` so the converter knows to begin. A power-down request returns a word of all ones instead of a result. It also drives `shutdown_n` low until the host next lowers the select.

All inputs are taken as synchronous to the fast system clock `clk`. Each half period of the serial clock lasts at least two `clk` cycles. The serial clock idles low.

Top module: `sadc_port`

## Requirements
- R1: With `cs_n` low, data-input bits of 0 before the first 1 are ignored. The first 1 sampled on a rising serial-clock edge is the start bit. Data-input values after the command has been taken are ignored until `cs_n` rises.
- R2: The seven bits after the start bit are taken in this order: single/differential, odd/sign, select-high, select-low, unipolar, MSB-first, power-up. Once the last bit is taken, `mux_addr` equals {single, odd, select-high, select-low} (bit 3 is single) and `unipolar` equals the unipolar bit.
- R3: `dout_en` is 0 after reset, while `cs_n` is high and while the command is being received. The first falling serial-clock edge after the command enables `dout` and drives a null bit of 0.
- R4: With MSB-first = 1 and power-up = 1, the next twelve falling edges drive B11 down to B0. Every later falling edge drives 0.
- R5: With MSB-first = 0, unipolar = 1 and power-up = 1, B0 is followed on the next eleven falling edges by B1 up to B11. Every later falling edge drives 0.
- R6: With MSB-first = 0, unipolar = 0 and power-up = 1, the sequence matches R5, but every position after the second B11 carries B11 (the sign) instead of 0.
- R7: With power-up = 0, the null bit is followed by twelve 1s and then 0s, whatever the order and coding bits say, and `conv_start` does not pulse.
- R8: `shutdown_n` goes low one `clk` after a command with power-up = 0 is taken. It stays low while `cs_n` is high and returns high one `clk` after the next falling edge of `cs_n`. The transaction that follows behaves normally.
- R9: Raising `cs_n` at any time forces `dout_en` to 0 on the next `clk`. It also restarts start-bit search and bit counting, so a partial command leaves no trace in the next transaction.
- R10: The data input is sampled only on rising serial-clock edges. `dout` changes only one `clk` after a falling serial-clock edge and stays put across rising edges.
- R11: A command with power-up = 1 gives exactly one `conv_start` pulse. The `result` word is latched at that moment, so later changes on `result` do not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; its high level aborts a transaction |
| din | input | 1 | Serial command input |
| result | input | DATA_W | Parallel conversion result from the converter model |
| dout | output | 1 | Serial result output |
| dout_en | output | 1 | Output enable for `dout`; 0 means high impedance |
| shutdown_n | output | 1 | Low while the converter is powered down |
| conv_start | output | 1 | One-cycle pulse asking the converter to sample and convert |
| mux_addr | output | 4 | Channel-select fields from the last command |
| unipolar | output | 1 | Coding bit from the last command |

## Verification
If the command bit counter is off by one, the fields land shifted in `mux_addr`. The whole result then arrives one serial period early or late, which the first compared data bit exposes. A wrong output position counter or tail flag shows up right after B0: the thirteenth data period carries B1 where 0 belongs, or the reverse, and a wrong fill register shows in the first fill period. A shutdown flag that is not cleared, or an output enable that survives a select release, shows at the port one `clk` after the select edge.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int CMD_BITS = 7;

    // Field order matches the shift order: first bit received sits in the MSB.
    typedef struct packed {
        logic sgl;
        logic odd;
        logic sel1;
        logic sel0;
        logic uni;
        logic msbf;
        logic pwr;
    } cmd_t;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_SHIFT,
        RX_HOLD
    } rx_state_e;

endpackage

// File: rtl/sadc_edges.sv
module sadc_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic sel_active
);

    typedef struct packed {
        logic sclk;
        logic cs_n;
    } edge_regs_t;

    edge_regs_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.sclk = sclk;
        e_d.cs_n = cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q.sclk <= 1'b0;
            e_q.cs_n <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign sel_active = ~cs_n;
    assign sclk_rise  = ~cs_n & sclk & ~e_q.sclk;
    assign sclk_fall  = ~cs_n & ~sclk & e_q.sclk;
    assign cs_fall    = ~cs_n & e_q.cs_n;

endmodule

// File: rtl/sadc_cmd.sv
module sadc_cmd
    import sadc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_active,
    input  logic sclk_rise,
    input  logic cs_fall,
    input  logic din,
    output cmd_t cmd,
    output logic cmd_done,
    output logic shutdown_n
);

    localparam int CNT_W = $clog2(CMD_BITS);

    typedef struct packed {
        rx_state_e            st;
        logic [CNT_W-1:0]     cnt;
        logic [CMD_BITS-1:0]  shreg;
        cmd_t                 cmd;
        logic                 done;
        logic                 sd_n;
    } cmd_regs_t;

    cmd_regs_t c_d, c_q;
    logic [CMD_BITS-1:0] sh_next;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        sh_next  = {c_q.shreg[CMD_BITS-2:0], din};
        if (cs_fall) begin
            c_d.sd_n = 1'b1;
        end
        if (!sel_active) begin
            c_d.st  = RX_HUNT;
            c_d.cnt = '0;
        end else if (sclk_rise) begin
            case (c_q.st)
                RX_HUNT: begin
                    if (din) begin
                        c_d.st  = RX_SHIFT;
                        c_d.cnt = '0;
                    end
                end
                RX_SHIFT: begin
                    c_d.shreg = sh_next;
                    if (c_q.cnt == CNT_W'(CMD_BITS - 1)) begin
                        c_d.st   = RX_HOLD;
                        c_d.cmd  = cmd_t'(sh_next);
                        c_d.done = 1'b1;
                        if (!din) begin
                            c_d.sd_n = 1'b0;
                        end
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st    <= RX_HUNT;
            c_q.cnt   <= '0;
            c_q.shreg <= '0;
            c_q.cmd   <= '0;
            c_q.done  <= 1'b0;
            c_q.sd_n  <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign cmd        = c_q.cmd;
    assign cmd_done   = c_q.done;
    assign shutdown_n = c_q.sd_n;

    // The command completes only on a rising serial edge seen by the edge unit.
    assert_done_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> $past(sclk_rise));

    // Shutdown entry coincides with a completed power-down command.
    assert_sd_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown_n) |-> (cmd_done && !cmd.pwr));

    // Shutdown release follows a falling select edge.
    assert_sd_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_n) |-> $past(cs_fall));

endmodule

// File: rtl/sadc_tx.sv
module sadc_tx #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_active,
    input  logic              sclk_fall,
    input  logic              cmd_done,
    input  logic              cmd_pwr,
    input  logic              cmd_msbf,
    input  logic              cmd_uni,
    input  logic [DATA_W-1:0] result,
    output logic              dout,
    output logic              dout_en
);

    localparam int POS_MAX = 2 * DATA_W;
    localparam int POS_W   = $clog2(POS_MAX + 1);

    typedef struct packed {
        logic              armed;
        logic [POS_W-1:0]  pos;
        logic [DATA_W-1:0] word;
        logic              tail;
        logic              fill;
        logic              dout;
        logic              en;
    } tx_regs_t;

    tx_regs_t t_d, t_q;
    logic [DATA_W-1:0] shifted;
    logic              cur_bit;

    // Bit for the current position: null, MSB-first run, LSB-first tail, fill.
    always_comb begin
        shifted = '0;
        cur_bit = 1'b0;
        if (t_q.pos == '0) begin
            cur_bit = 1'b0;
        end else if (t_q.pos <= POS_W'(DATA_W)) begin
            shifted = t_q.word >> (POS_W'(DATA_W) - t_q.pos);
            cur_bit = shifted[0];
        end else if (t_q.tail && (t_q.pos < POS_W'(POS_MAX))) begin
            shifted = t_q.word >> (t_q.pos - POS_W'(DATA_W));
            cur_bit = shifted[0];
        end else begin
            cur_bit = t_q.fill;
        end
    end

    always_comb begin
        t_d = t_q;
        if (!sel_active) begin
            t_d.armed = 1'b0;
            t_d.en    = 1'b0;
            t_d.dout  = 1'b0;
            t_d.pos   = '0;
        end else if (cmd_done) begin
            t_d.armed = 1'b1;
            t_d.pos   = '0;
            t_d.word  = cmd_pwr ? result : '1;
            t_d.tail  = cmd_pwr & ~cmd_msbf;
            t_d.fill  = cmd_pwr & ~cmd_msbf & ~cmd_uni & result[DATA_W-1];
        end else if (sclk_fall && t_q.armed) begin
            t_d.en   = 1'b1;
            t_d.dout = cur_bit;
            if (t_q.pos != POS_W'(POS_MAX)) begin
                t_d.pos = t_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.armed <= 1'b0;
            t_q.pos   <= '0;
            t_q.word  <= '0;
            t_q.tail  <= 1'b0;
            t_q.fill  <= 1'b0;
            t_q.dout  <= 1'b0;
            t_q.en    <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign dout    = t_q.dout;
    assign dout_en = t_q.en;

    // Output data moves only after a falling serial edge while selected.
    assert_dout_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_active) && !$stable(dout)) |-> $past(sclk_fall));

    // The output driver turns on only after a falling serial edge.
    assert_en_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> $past(sclk_fall && sel_active));

    // The first driven bit is the null bit.
    assert_null_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> !dout);

endmodule

// File: rtl/sadc_port.sv
module sadc_port
    import sadc_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    input  logic [DATA_W-1:0] result,
    output logic              dout,
    output logic              dout_en,
    output logic              shutdown_n,
    output logic              conv_start,
    output logic [3:0]        mux_addr,
    output logic              unipolar
);

    logic sclk_rise, sclk_fall, cs_fall, sel_active;
    logic cmd_done;
    cmd_t cmd;

    sadc_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .cs_fall    (cs_fall),
        .sel_active (sel_active)
    );

    sadc_cmd u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_active (sel_active),
        .sclk_rise  (sclk_rise),
        .cs_fall    (cs_fall),
        .din        (din),
        .cmd        (cmd),
        .cmd_done   (cmd_done),
        .shutdown_n (shutdown_n)
    );

    sadc_tx #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_active (sel_active),
        .sclk_fall  (sclk_fall),
        .cmd_done   (cmd_done),
        .cmd_pwr    (cmd.pwr),
        .cmd_msbf   (cmd.msbf),
        .cmd_uni    (cmd.uni),
        .result     (result),
        .dout       (dout),
        .dout_en    (dout_en)
    );

    assign conv_start = cmd_done & cmd.pwr;
    assign mux_addr   = {cmd.sgl, cmd.odd, cmd.sel1, cmd.sel0};
    assign unipolar   = cmd.uni;

    // Releasing the select turns the output driver off on the next clock.
    assert_hiz_on_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !dout_en);

    // A conversion request never comes with the converter powered down.
    assert_conv_powered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> shutdown_n);

endmodule

// File: tb/tb_sadc_port.sv
module tb_sadc_port;

    localparam int DW    = 12;
    localparam int HALF  = 3;
    localparam int OUTP  = 30;
    localparam int NVEC  = 8;

    logic          clk    = 1'b0;
    logic          rst_n  = 1'b0;
    logic          sclk   = 1'b0;
    logic          cs_n   = 1'b1;
    logic          din    = 1'b0;
    logic [DW-1:0] result = '0;
    logic          dout, dout_en, shutdown_n, conv_start, unipolar;
    logic [3:0]    mux_addr;

    int n_chk = 0;
    int n_bad = 0;
    int conv_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sadc_port #(.DATA_W(DW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .din        (din),
        .result     (result),
        .dout       (dout),
        .dout_en    (dout_en),
        .shutdown_n (shutdown_n),
        .conv_start (conv_start),
        .mux_addr   (mux_addr),
        .unipolar   (unipolar)
    );

    always @(negedge clk) if (rst_n && conv_start) conv_cnt++;

    // Vector fields: lead zeros [21:19], command [18:12] = sgl,odd,sel1,sel0,uni,msbf,pwr, result [11:0].
    localparam logic [21:0] VEC [NVEC] = '{
        {3'd0, 7'b1000111, 12'hA5C},
        {3'd2, 7'b0110101, 12'h3E7},
        {3'd1, 7'b1101001, 12'h9B2},
        {3'd0, 7'b0011001, 12'h4D1},
        {3'd3, 7'b1011011, 12'hFFF},
        {3'd0, 7'b0100110, 12'h123},
        {3'd1, 7'b1001000, 12'h800},
        {3'd0, 7'b0001101, 12'h001}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // {enable, bit} expected in output period k (k<0: still receiving).
    function automatic logic [1:0] want(input int k, input logic [6:0] c, input logic [11:0] r);
        logic pwr  = c[0];
        logic msbf = c[1];
        logic uni  = c[2];
        logic fill = pwr & ~msbf & ~uni & r[11];
        if (k < 0)  return 2'b00;
        if (k == 0) return 2'b10;
        if (k <= 12) return {1'b1, pwr ? r[12-k] : 1'b1};
        if (k <= 23 && pwr && !msbf) return {1'b1, r[k-12]};
        return {1'b1, fill};
    endfunction

    function automatic string req_of(input int k, input logic [6:0] c);
        if (k <= 0)  return "R3";
        if (!c[0])   return "R7";
        if (c[1])    return "R4";
        if (c[2])    return "R5";
        return "R6";
    endfunction

    task automatic txn(input int lead, input logic [6:0] c, input logic [11:0] r,
                       input int out_len);
        int   c0 = conv_cnt;
        logic held_bit;
        logic [1:0] e;
        result = r;
        cs_n   = 1'b0;
        tick(2);
        chk("R8", 32'(shutdown_n), 32'd1, "released after select fall");
        for (int p = 0; p < lead + 8 + out_len; p++) begin
            int k = p - lead - 8;
            logic b;
            if (p < lead)            b = 1'b0;
            else if (p == lead)      b = 1'b1;
            else if (p <= lead + 7)  b = c[6 - (p - lead - 1)];
            else                     b = p[0];   // R1: ignored after the command
            sclk = 1'b0;
            din  = b;
            if (k == 0) begin
                result = ~r;                   // R11: latched word must not change
                chk("R11", 32'(conv_cnt - c0), 32'(c[0]), "conversion pulses");
                chk("R8", 32'(shutdown_n), 32'(c[0]), "shutdown flag");
            end
            tick(HALF);
            e = want(k, c, r);
            chk(req_of(k, c), 32'(dout_en), 32'(e[1]), $sformatf("enable period %0d", k));
            if (e[1]) chk(req_of(k, c), 32'(dout), 32'(e[0]), $sformatf("bit period %0d", k));
            held_bit = dout;
            sclk = 1'b1;
            tick(1);
            chk("R10", 32'(dout), 32'(held_bit), $sformatf("stable on rise %0d", k));
            tick(HALF - 1);
        end
        sclk = 1'b0;
        tick(HALF);
        chk("R2", 32'(mux_addr), 32'(c[6:3]), "channel fields");
        chk("R2", 32'(unipolar), 32'(c[2]), "coding bit");
        cs_n = 1'b1;
        tick(1);
        chk("R9", 32'(dout_en), 32'd0, "driver off after release");
        tick(1);
        chk("R8", 32'(shutdown_n), 32'(c[0]), "flag held while deselected");
        tick(2);
    endtask

    initial begin
        tick(3);
        chk("R3", 32'(dout_en), 32'd0, "enable in reset");
        chk("R8", 32'(shutdown_n), 32'd1, "flag in reset");
        rst_n = 1'b1;
        tick(3);
        chk("R3", 32'(dout_en), 32'd0, "enable after reset");
        chk("R11", 32'(conv_start), 32'd0, "no pulse after reset");

        for (int i = 0; i < NVEC; i++) begin
            txn(int'(VEC[i][21:19]), VEC[i][18:12], VEC[i][11:0], OUTP);
        end

        // R9: abort inside the command, then a clean transaction.
        cs_n = 1'b0;
        tick(2);
        for (int p = 0; p < 4; p++) begin
            sclk = 1'b0; din = (p != 2); tick(HALF);
            sclk = 1'b1; tick(HALF);
        end
        sclk = 1'b0;
        cs_n = 1'b1;
        tick(1);
        chk("R9", 32'(dout_en), 32'd0, "abort in command");
        tick(3);
        txn(1, 7'b0111111, 12'h5A6, OUTP);

        // R9: abort during the data phase, then another full transaction.
        txn(0, 7'b1100101, 12'hC3A, 6);
        txn(2, 7'b0010001, 12'h7E1, OUTP);

        // R8: shutdown then an immediate normal cycle.
        txn(0, 7'b1111110, 12'h000, 4);
        txn(0, 7'b1010011, 12'hB44, OUTP);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
            $finish;
        end
    end

endmodule